// File: doc/BRIEF.md
# Synchronous Sync Character Hunter

This block sits at the front of a bit-serial synchronous receiver and finds where characters begin. After reset, or when the hunt command is pulsed, it enters hunt phase. In that phase each accepted serial bit is shifted into a sync register. The last N bits are compared against the programmed pattern. N is 6, 8 or 16 depending on the mode.

When the pattern is found, the block leaves hunt phase and pulses a sync indication for one cycle. From the next accepted bit on, it frames characters of the selected length. Each completed character is presented on a parallel output with a one-cycle valid strike.

In the single-character modes, characters that repeat the sync pattern are normally suppressed, as are the programmed pair in the two-character mode. A strip-disable input lets them through. The block stays in character phase until the hunt command is pulsed again.

Top module: `sync_hunter`

## Requirements
- R1: While reset is low and in the first cycle after it, `hunting` is 1 and `sync_det` and `char_vld` are 0.
- R2: Mode 0 (6-bit) matches the last six accepted bits against `pat_a[5:0]`. The earliest of the six bits is compared with `pat_a[5]`.
- R3: Mode 1 (8-bit single character) matches the last eight accepted bits against `pat_a`. The earliest bit is compared with `pat_a[7]`.
- R4: Modes 2 (two-character) and 3 (16-bit) both match the last sixteen accepted bits against `{pat_a, pat_b}`. The earliest bit is compared with `pat_a[7]`. Eight bits that equal `pat_b` alone never match.
- R5: When the bit that completes a match is taken at a clock edge, `sync_det` is 1 and `hunting` is 0 from that edge for exactly one cycle. `hunting` then stays 0, and no further `sync_det` occurs, until a hunt command.
- R6: A match needs at least as many accepted bits since the last hunt entry as the pattern length.
- R7: Bits are taken only in cycles with `bit_vld` = 1. `bit_in` is ignored otherwise.
- R8: Character length is 5 + `char_len` bits (codes 0..3 give 5..8). Framing starts with the bit after the pattern. The first bit of a character is its MSB. `char_out` is right-justified with upper bits zero. `char_vld` pulses for one cycle after the edge that takes the last bit.
- R9: In modes 1 and 2, with `strip_dis` = 0, a character equal to the low bits of `pat_a` is dropped. In mode 2, one equal to the low bits of `pat_b` is also dropped. In modes 0 and 3, or with `strip_dis` = 1, every character is output.
- R10: A `hunt_cmd` cycle sets `hunting` to 1 at the next edge. It discards any partial character and the bit offered in that same cycle, and it restarts the R6 bit count.
- R11: `char_vld` is never 1 while `hunting` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial received data bit |
| bit_vld | input | 1 | Strobe: `bit_in` holds a new bit this cycle |
| hunt_cmd | input | 1 | Enter hunt phase |
| mode | input | 2 | 0: 6-bit, 1: 8-bit single, 2: two-character, 3: 16-bit |
| pat_a | input | PAT_W | First pattern register (upper byte in 16-bit compare) |
| pat_b | input | PAT_W | Second pattern register |
| char_len | input | 2 | Character length code, length = CHAR_MAX-3+code |
| strip_dis | input | 1 | 1 passes sync-valued characters through |
| hunting | output | 1 | 1 while in hunt phase |
| sync_det | output | 1 | One-cycle pulse on pattern match |
| char_out | output | CHAR_MAX | Last framed character, right-justified |
| char_vld | output | 1 | One-cycle strobe for `char_out` |

## Verification
The bench builds the block with its defaults, an 8-bit pattern register width and an 8-bit maximum character. This makes all four pattern lengths and all four character lengths, 5 to 8 bits, reachable through the mode and length inputs. With these values, the 6-bit mode compares only part of one register, and the stripping comparison is tested both at full character width and truncated to five and six bits. Streams are built so that an early false match would be visible, for example an isolated second pattern byte in two-character mode and a zero pattern that reset contents could satisfy.

// File: rtl/sync_hunter_pkg.sv
package sync_hunter_pkg;

   typedef enum logic [1:0] {
      HM_MONO6  = 2'd0,
      HM_MONO8  = 2'd1,
      HM_BISYNC = 2'd2,
      HM_WORD16 = 2'd3
   } hunt_mode_e;

   function automatic logic is_pair(input hunt_mode_e m);
      return (m == HM_BISYNC) || (m == HM_WORD16);
   endfunction

endpackage

// File: rtl/sync_match.sv
module sync_match
   import sync_hunter_pkg::*;
#(
   parameter int PAT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift,
   input  logic             bit_in,
   input  hunt_mode_e       mode,
   input  logic [PAT_W-1:0] pat_a,
   input  logic [PAT_W-1:0] pat_b,
   output logic             match
);

   localparam int SR_W = 2 * PAT_W;
   localparam int FW   = $clog2(SR_W + 1);
   localparam int SHORT_W = PAT_W - 2;

   logic [SR_W-1:0] sr_q, sr_nxt;
   logic [FW-1:0]   fill_q, fill_nxt;
   logic [SR_W-1:0] target, mask;
   logic [FW-1:0]   need;

   assign sr_nxt   = {sr_q[SR_W-2:0], bit_in};
   assign fill_nxt = (fill_q < FW'(SR_W)) ? fill_q + 1'b1 : fill_q;

   always_comb begin
      target = '0;
      mask   = '0;
      need   = '0;
      unique case (mode)
         HM_MONO6: begin
            target[SHORT_W-1:0] = pat_a[SHORT_W-1:0];
            mask[SHORT_W-1:0]   = '1;
            need = FW'(SHORT_W);
         end
         HM_MONO8: begin
            target[PAT_W-1:0] = pat_a;
            mask[PAT_W-1:0]   = '1;
            need = FW'(PAT_W);
         end
         default: begin
            target = {pat_a, pat_b};
            mask   = '1;
            need   = FW'(SR_W);
         end
      endcase
   end

   assign match = shift && (fill_nxt >= need) && (((sr_nxt ^ target) & mask) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sr_q   <= '0;
         fill_q <= '0;
      end else if (shift) begin
         sr_q   <= sr_nxt;
         fill_q <= fill_nxt;
      end
   end

endmodule

// File: rtl/char_frame.sv
module char_frame #(
   parameter int CHAR_MAX = 8
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                shift,
   input  logic                bit_in,
   input  logic [1:0]          len_code,
   output logic                done,
   output logic [CHAR_MAX-1:0] word,
   output logic [CHAR_MAX-1:0] len_mask
);

   localparam int CW = $clog2(CHAR_MAX + 1);

   logic [CHAR_MAX-1:0] acc_q, acc_nxt;
   logic [CW-1:0]       cnt_q;
   logic [CW-1:0]       len;

   assign len      = CW'(CHAR_MAX - 3) + CW'(len_code);
   assign len_mask = {CHAR_MAX{1'b1}} >> (CW'(CHAR_MAX) - len);
   assign acc_nxt  = {acc_q[CHAR_MAX-2:0], bit_in};
   assign done     = shift && (cnt_q == len - 1'b1);
   assign word     = acc_nxt & len_mask;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (done) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (shift) begin
         acc_q <= acc_nxt;
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/strip_filter.sv
module strip_filter
   import sync_hunter_pkg::*;
#(
   parameter int PAT_W    = 8,
   parameter int CHAR_MAX = 8
)(
   input  hunt_mode_e          mode,
   input  logic                strip_dis,
   input  logic [CHAR_MAX-1:0] word,
   input  logic [CHAR_MAX-1:0] len_mask,
   input  logic [PAT_W-1:0]    pat_a,
   input  logic [PAT_W-1:0]    pat_b,
   output logic                drop
);

   logic eq_a, eq_b;

   assign eq_a = ((word ^ pat_a[CHAR_MAX-1:0]) & len_mask) == '0;
   assign eq_b = ((word ^ pat_b[CHAR_MAX-1:0]) & len_mask) == '0;

   always_comb begin
      drop = 1'b0;
      if (!strip_dis) begin
         if (mode == HM_MONO8)
            drop = eq_a;
         else if (mode == HM_BISYNC)
            drop = eq_a || eq_b;
      end
   end

endmodule

// File: rtl/sync_hunter.sv
module sync_hunter
   import sync_hunter_pkg::*;
#(
   parameter int PAT_W    = 8,
   parameter int CHAR_MAX = 8
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_in,
   input  logic                bit_vld,
   input  logic                hunt_cmd,
   input  logic [1:0]          mode,
   input  logic [PAT_W-1:0]    pat_a,
   input  logic [PAT_W-1:0]    pat_b,
   input  logic [1:0]          char_len,
   input  logic                strip_dis,
   output logic                hunting,
   output logic                sync_det,
   output logic [CHAR_MAX-1:0] char_out,
   output logic                char_vld
);

   generate
      if (PAT_W < 6) begin : g_bad_pat
         $error("PAT_W must be at least 6");
      end
      if (CHAR_MAX < 4 || CHAR_MAX > PAT_W) begin : g_bad_char
         $error("CHAR_MAX must lie in 4..PAT_W");
      end
   endgenerate

   hunt_mode_e          mode_e;
   logic                hunt_shift, frame_shift;
   logic                match, done, drop;
   logic [CHAR_MAX-1:0] word, len_mask;

   assign mode_e      = hunt_mode_e'(mode);
   assign hunt_shift  = hunting  && bit_vld && !hunt_cmd;
   assign frame_shift = !hunting && bit_vld && !hunt_cmd;

   sync_match #(.PAT_W(PAT_W)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (hunt_cmd),
      .shift  (hunt_shift),
      .bit_in (bit_in),
      .mode   (mode_e),
      .pat_a  (pat_a),
      .pat_b  (pat_b),
      .match  (match)
   );

   char_frame #(.CHAR_MAX(CHAR_MAX)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (hunt_cmd),
      .shift    (frame_shift),
      .bit_in   (bit_in),
      .len_code (char_len),
      .done     (done),
      .word     (word),
      .len_mask (len_mask)
   );

   strip_filter #(.PAT_W(PAT_W), .CHAR_MAX(CHAR_MAX)) u_strip (
      .mode      (mode_e),
      .strip_dis (strip_dis),
      .word      (word),
      .len_mask  (len_mask),
      .pat_a     (pat_a),
      .pat_b     (pat_b),
      .drop      (drop)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hunting  <= 1'b1;
         sync_det <= 1'b0;
         char_vld <= 1'b0;
         char_out <= '0;
      end else begin
         sync_det <= 1'b0;
         char_vld <= 1'b0;
         if (hunt_cmd) begin
            hunting <= 1'b1;
         end else if (match) begin
            hunting  <= 1'b0;
            sync_det <= 1'b1;
         end
         if (done && !drop) begin
            char_vld <= 1'b1;
            char_out <= word;
         end
      end
   end

endmodule

// File: rtl/sync_hunter_chk.sv
module sync_hunter_chk (
   input logic clk,
   input logic rst_n,
   input logic hunt_cmd,
   input logic hunting,
   input logic sync_det,
   input logic char_vld
);

   // R5
   sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_det |=> !sync_det);

   // R5
   sync_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_det |-> (!hunting && $past(hunting)));

   // R5
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hunting && !hunt_cmd) |=> !hunting);

   // R10
   hunt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_cmd |=> (hunting && !char_vld && !sync_det));

   // R11
   quiet_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hunting |-> !char_vld);

endmodule

bind sync_hunter sync_hunter_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hunt_cmd (hunt_cmd),
   .hunting  (hunting),
   .sync_det (sync_det),
   .char_vld (char_vld)
);

// File: tb/sync_hunter_test.sv
`timescale 1ns/1ps
module sync_hunter_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_in = 1'b0, bit_vld = 1'b0, hunt_cmd = 1'b0;
   logic [1:0] mode = 2'd0, char_len = 2'd3;
   logic [7:0] pat_a = 8'h00, pat_b = 8'h00;
   logic       strip_dis = 1'b0;
   logic       hunting, sync_det, char_vld;
   logic [7:0] char_out;

   int checks = 0, fails = 0;
   int nsync = 0, nchar = 0;
   logic [7:0] lastc = 8'h00;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sync_hunter uut (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
      .hunt_cmd(hunt_cmd), .mode(mode), .pat_a(pat_a), .pat_b(pat_b),
      .char_len(char_len), .strip_dis(strip_dis), .hunting(hunting),
      .sync_det(sync_det), .char_out(char_out), .char_vld(char_vld)
   );

   always @(posedge clk) begin
      #1;
      if (sync_det) nsync++;
      if (char_vld) begin nchar++; lastc = char_out; end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      bit_in = b; bit_vld = 1'b1;
      @(negedge clk);
      bit_vld = 1'b0;
   endtask

   task automatic send_bits(input logic [15:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic enter_hunt();
      hunt_cmd = 1'b1;
      @(negedge clk);
      hunt_cmd = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 hunting", hunting, 1);
      chk("R1 sync_det", sync_det, 0);
      chk("R1 char_vld", char_vld, 0);
   endtask

   task automatic t_mono6();
      int ns, nc;
      mode = 2'd0; pat_a = 8'hE5; char_len = 2'd3;
      enter_hunt();
      ns = nsync;
      send_bits(16'h0012, 7);
      chk("R2 no early sync", nsync, ns);
      send_bit(1'b1);
      chk("R2 sync_det", sync_det, 1);
      chk("R5 hunting low", hunting, 0);
      nc = nchar;
      send_bits(16'h00A3, 8);
      chk("R8 char_vld", char_vld, 1);
      chk("R8 char_out", char_out, 8'hA3);
      chk("R5 single pulse", nsync, ns + 1);
      chk("R8 one char", nchar, nc + 1);
   endtask

   task automatic t_mono8_strip();
      int ns, nc;
      mode = 2'd1; pat_a = 8'h96; char_len = 2'd3; strip_dis = 1'b0;
      enter_hunt();
      send_bits(16'h0096, 8);
      chk("R3 sync_det", sync_det, 1);
      ns = nsync; nc = nchar;
      send_bits(16'h0096, 8);
      chk("R9 stripped", nchar, nc);
      chk("R5 no resync", nsync, ns);
      send_bits(16'h003C, 8);
      chk("R9 passed count", nchar, nc + 1);
      chk("R9 passed value", lastc, 8'h3C);
      strip_dis = 1'b1;
      send_bits(16'h0096, 8);
      chk("R9 strip_dis count", nchar, nc + 2);
      chk("R9 strip_dis value", lastc, 8'h96);
      strip_dis = 1'b0;
   endtask

   task automatic t_fill();
      int ns;
      mode = 2'd1; pat_a = 8'h00;
      enter_hunt();
      ns = nsync;
      send_bits(16'h0000, 7);
      chk("R6 seven bits no sync", nsync, ns);
      send_bit(1'b0);
      chk("R6 eighth bit sync", sync_det, 1);
   endtask

   task automatic t_bisync();
      int ns, nc;
      mode = 2'd2; pat_a = 8'h32; pat_b = 8'h7E; char_len = 2'd0;
      enter_hunt();
      ns = nsync;
      send_bits(16'h007E, 8);
      chk("R4 second byte alone", nsync, ns);
      send_bits(16'h0032, 8);
      send_bits(16'h007E, 8);
      chk("R4 pair sync", sync_det, 1);
      chk("R4 one sync", nsync, ns + 1);
      nc = nchar;
      send_bits(16'h001E, 5);
      chk("R9 pat_b stripped", nchar, nc);
      send_bits(16'h0012, 5);
      chk("R9 pat_a stripped", nchar, nc);
      send_bits(16'h0015, 5);
      chk("R8 5-bit count", nchar, nc + 1);
      chk("R8 5-bit value", lastc, 8'h15);
   endtask

   task automatic t_word16();
      int nc;
      mode = 2'd3; pat_a = 8'h32; pat_b = 8'h7E; char_len = 2'd1;
      enter_hunt();
      send_bits(16'h327E, 16);
      chk("R4 16-bit sync", sync_det, 1);
      nc = nchar;
      send_bits(16'h0032, 6);
      chk("R9 no strip in mode 3", nchar, nc + 1);
      chk("R8 6-bit value", lastc, 8'h32);
   endtask

   task automatic t_gaps();
      logic [7:0] p;
      int ns, nc;
      p = 8'hA5;
      mode = 2'd1; pat_a = p; char_len = 2'd3;
      enter_hunt();
      ns = nsync;
      for (int i = 7; i >= 1; i--) begin
         send_bit(p[i]);
         bit_in = ~p[i];
         repeat (3) @(negedge clk);
      end
      chk("R7 gaps no early sync", nsync, ns);
      send_bit(p[0]);
      chk("R7 sync after gaps", sync_det, 1);
      nc = nchar;
      send_bits(16'h000C, 4);
      for (int i = 0; i < 5; i++) begin
         bit_in = i[0];
         @(negedge clk);
      end
      chk("R7 idle no char", nchar, nc);
      send_bits(16'h0009, 4);
      chk("R7 char ignores idle", lastc, 8'hC9);
   endtask

   task automatic t_rehunt();
      int ns, nc;
      mode = 2'd1; pat_a = 8'h5A; char_len = 2'd3;
      enter_hunt();
      send_bits(16'h005A, 8);
      chk("R3 sync 5A", sync_det, 1);
      send_bits(16'h000F, 4);
      hunt_cmd = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
      @(negedge clk);
      hunt_cmd = 1'b0; bit_vld = 1'b0;
      chk("R10 hunting set", hunting, 1);
      nc = nchar; ns = nsync;
      send_bits(16'h00FF, 8);
      chk("R11 no char in hunt", nchar, nc);
      send_bits(16'h005A, 8);
      chk("R10 resync", nsync, ns + 1);
      send_bits(16'h00C3, 8);
      chk("R10 partial discarded", lastc, 8'hC3);
      chk("R10 one char", nchar, nc + 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 hunting in reset", hunting, 1);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mono6();
      t_mono8_strip();
      t_fill();
      t_bisync();
      t_word16();
      t_gaps();
      t_rehunt();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule